// File: doc/BRIEF.md
# Four-Channel Serial Audio Frame Link

This block carries four 16-bit audio channels over a one-way, three-wire serial link. The link consists of a bit clock, an end-of-frame strobe and a data line. The transmitter holds the most recent set of four parallel samples. It divides the system clock down to a continuous bit clock. It sends one 64-bit frame after another, least significant bit of channel 0 first. The strobe is raised during the last bit of every frame. The clock and the strobe come from one source only.

The receiver samples data on each rising bit-clock edge and keeps a running bit count. When it sees the strobe, it latches the whole shifted frame and presents the four channels as parallel words, marked by a one-cycle valid pulse. If the strobe arrives after a number of bits other than 64, the receiver throws that frame away and raises an error pulse.

An optional pass-through output re-times the incoming data line by one system clock, so that nodes can be chained. All logic runs on one system clock: the receive bit clock is treated as a synchronous input and its edges are found by comparing it with its value in the previous cycle.

Top module: `aud4_link`

## Requirements
- R1: While reset is held, tx_bclk is 1, tx_ident and tx_sdata are 0, rx_valid and rx_err are 0, rx_samples is all zero and thru_sdata is 0.
- R2: tx_bclk runs continuously, staying high for BCLK_HALF system clocks and then low for BCLK_HALF system clocks.
- R3: tx_sdata and tx_ident change only in the system-clock cycle in which tx_bclk falls.
- R4: Each frame is 64 bits sent on consecutive bit periods. Frame bit n is sent in the n-th bit period after the frame starts. Channel k (element k of tx_samples) occupies frame bits 16k to 16k+15, so frame bit 0 is bit 0 of channel 0.
- R5: tx_ident is high for exactly one bit period per frame, and that period is the one carrying frame bit 63.
- R6: The transmit output register is loaded at the falling bit-clock edge that ends the tx_ident period, from the last samples presented with tx_valid. If tx_valid is high in the same system-clock cycle as that load, the new samples take precedence. Samples presented one cycle later wait for the following frame. The held samples are resent until new ones arrive.
- R7: The receiver shifts rx_sdata in on every rising edge of rx_bclk. On a rising edge where rx_ident is high and exactly 64 bits have been received since the previous strobe (or since reset), it updates rx_samples with the frame, using the same channel layout as R4, and pulses rx_valid for one system clock.
- R8: A strobe arriving after a bit count other than 64 produces a one-cycle rx_err pulse and no rx_valid. rx_samples is left unchanged, and the bit count restarts so that the next 64-bit frame is accepted.
- R9: With PASS_THRU=1, thru_sdata equals rx_sdata delayed by one system clock. With PASS_THRU=0, it is constant 0.
- R10: rx_samples holds its value between accepted frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Capture tx_samples into the transmit holding register |
| tx_samples | input | 4x16 | Four channel samples to transmit, element k is channel k |
| tx_bclk | output | 1 | Generated bit clock |
| tx_ident | output | 1 | End-of-frame strobe, high during frame bit 63 |
| tx_sdata | output | 1 | Serial data, changes on falling bit clock |
| rx_bclk | input | 1 | Received bit clock |
| rx_ident | input | 1 | Received end-of-frame strobe |
| rx_sdata | input | 1 | Received serial data |
| rx_samples | output | 4x16 | Last accepted frame, element k is channel k |
| rx_valid | output | 1 | One-cycle pulse when rx_samples is updated |
| rx_err | output | 1 | One-cycle pulse when a frame of wrong length is rejected |
| thru_sdata | output | 1 | Re-timed copy of rx_sdata for daisy chaining |

## Verification
Two events can meet in one system-clock cycle. The first is a new tx_valid sample set arriving. The second is the frame load that follows the strobe. The bench finds the first high cycle of tx_bclk during tx_ident and counts forward to the cycle just before the falling edge. It pulses tx_valid exactly there, and then again one cycle later. The frames received back must show the new set winning the coincident cycle and the late set appearing only one frame afterwards. The same strobe edge also decides between latching and rejecting in the receiver. Short and long frames are driven directly onto the receive pins to confirm that only one of the two pulses appears and that the held samples survive.

// File: rtl/aud4_pkg.sv
package aud4_pkg;
    parameter int CH_NUM  = 4;
    parameter int SAMP_W  = 16;
    localparam int FRAME_W = CH_NUM * SAMP_W;
    localparam int BIDX_W  = $clog2(FRAME_W);
    localparam int BCNT_W  = BIDX_W + 1;

    typedef logic [FRAME_W-1:0] frame_t;
endpackage

// File: rtl/aud4_bclk_gen.sv
module aud4_bclk_gen #(
    parameter int BCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk_o,
    output logic fall_o,
    output logic rise_o
);
    localparam int CW = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(BCLK_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          bclk;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == CNT_LAST);
        if (wrap) begin
            st_d.cnt  = '0;
            st_d.bclk = ~st_q.bclk;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.bclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk_o = st_q.bclk;
    assign fall_o = wrap && st_q.bclk;
    assign rise_o = wrap && !st_q.bclk;

    assert_tick_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_o, rise_o}));
    assert_fall_lowers_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !bclk_o);
    assert_rise_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> bclk_o);
endmodule

// File: rtl/aud4_tx.sv
module aud4_tx
    import aud4_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fall_i,
    input  logic   smp_vld_i,
    input  frame_t smp_i,
    output logic   sdata_o,
    output logic   ident_o
);
    localparam logic [BIDX_W-1:0] BIT_LAST = BIDX_W'(FRAME_W - 1);

    typedef struct packed {
        frame_t             hold;
        frame_t             shreg;
        logic [BIDX_W-1:0]  bidx;
        logic               sdata;
        logic               ident;
    } tx_st_t;

    tx_st_t st_d, st_q;
    frame_t load_src;

    always_comb begin
        st_d     = st_q;
        load_src = smp_vld_i ? smp_i : st_q.hold;
        if (smp_vld_i) begin
            st_d.hold = smp_i;
        end
        if (fall_i) begin
            if (st_q.bidx == BIT_LAST) begin
                st_d.bidx  = '0;
                st_d.sdata = load_src[0];
                st_d.shreg = load_src >> 1;
            end else begin
                st_d.bidx  = st_q.bidx + 1'b1;
                st_d.sdata = st_q.shreg[0];
                st_d.shreg = st_q.shreg >> 1;
            end
            st_d.ident = (st_d.bidx == BIT_LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold  <= '0;
            st_q.shreg <= '0;
            st_q.bidx  <= BIT_LAST;
            st_q.sdata <= 1'b0;
            st_q.ident <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdata_o = st_q.sdata;
    assign ident_o = st_q.ident;

    assert_edge_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> ($stable(sdata_o) && $stable(ident_o)));
    assert_ident_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ident_o && fall_i) |=> !ident_o);
endmodule

// File: rtl/aud4_rx.sv
module aud4_rx
    import aud4_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bclk_i,
    input  logic   ident_i,
    input  logic   sdata_i,
    output frame_t samples_o,
    output logic   valid_o,
    output logic   err_o
);
    localparam logic [BCNT_W-1:0] CNT_LAST = BCNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic               bprev;
        frame_t             shreg;
        logic [BCNT_W-1:0]  cnt;
        frame_t             frame;
        logic               valid;
        logic               err;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   rise;

    always_comb begin
        st_d       = st_q;
        rise       = bclk_i && !st_q.bprev;
        st_d.bprev = bclk_i;
        st_d.valid = 1'b0;
        st_d.err   = 1'b0;
        if (rise) begin
            st_d.shreg = {sdata_i, st_q.shreg[FRAME_W-1:1]};
            if (ident_i) begin
                if (st_q.cnt == CNT_LAST) begin
                    st_d.frame = st_d.shreg;
                    st_d.valid = 1'b1;
                end else begin
                    st_d.err = 1'b1;
                end
                st_d.cnt = '0;
            end else if (st_q.cnt != '1) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bprev <= 1'b1;
            st_q.shreg <= '0;
            st_q.cnt   <= '0;
            st_q.frame <= '0;
            st_q.valid <= 1'b0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign samples_o = st_q.frame;
    assign valid_o   = st_q.valid;
    assign err_o     = st_q.err;

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    assert_valid_after_ident_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(ident_i && bclk_i));
    assert_err_xor_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({valid_o, err_o}));
    assert_err_keeps_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(samples_o));
    assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(samples_o));
endmodule

// File: rtl/aud4_link.sv
module aud4_link
    import aud4_pkg::*;
#(
    parameter int BCLK_HALF = 2,
    parameter bit PASS_THRU = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tx_valid,
    input  logic [CH_NUM-1:0][SAMP_W-1:0]  tx_samples,
    output logic                           tx_bclk,
    output logic                           tx_ident,
    output logic                           tx_sdata,
    input  logic                           rx_bclk,
    input  logic                           rx_ident,
    input  logic                           rx_sdata,
    output logic [CH_NUM-1:0][SAMP_W-1:0]  rx_samples,
    output logic                           rx_valid,
    output logic                           rx_err,
    output logic                           thru_sdata
);
    logic   fall_tick;
    logic   rise_tick;
    frame_t rx_frame;

    aud4_bclk_gen #(.BCLK_HALF(BCLK_HALF)) u_bclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_o (tx_bclk),
        .fall_o (fall_tick),
        .rise_o (rise_tick)
    );

    aud4_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (fall_tick),
        .smp_vld_i (tx_valid),
        .smp_i     (frame_t'(tx_samples)),
        .sdata_o   (tx_sdata),
        .ident_o   (tx_ident)
    );

    aud4_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (rx_bclk),
        .ident_i   (rx_ident),
        .sdata_i   (rx_sdata),
        .samples_o (rx_frame),
        .valid_o   (rx_valid),
        .err_o     (rx_err)
    );

    assign rx_samples = rx_frame;

    generate
        if (PASS_THRU) begin : g_thru
            logic thru_d, thru_q;
            always_comb thru_d = rx_sdata;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) thru_q <= 1'b0;
                else        thru_q <= thru_d;
            end
            assign thru_sdata = thru_q;
            assert_thru_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(thru_sdata) |-> $past(rx_sdata));
        end else begin : g_no_thru
            assign thru_sdata = 1'b0;
        end
    endgenerate

    assert_tick_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> $stable(tx_sdata));
endmodule

// File: tb/aud4_link_tb.sv
module aud4_link_tb;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic               tx_valid = 1'b0;
    logic [3:0][15:0]   tx_samples = '0;
    logic               tx_bclk, tx_ident, tx_sdata;
    logic               rx_bclk, rx_ident, rx_sdata;
    logic [3:0][15:0]   rx_samples;
    logic               rx_valid, rx_err, thru_sdata;

    logic man_mode  = 1'b0;
    logic man_bclk  = 1'b1;
    logic man_ident = 1'b0;
    logic man_sdata = 1'b0;

    assign rx_bclk  = man_mode ? man_bclk  : tx_bclk;
    assign rx_ident = man_mode ? man_ident : tx_ident;
    assign rx_sdata = man_mode ? man_sdata : tx_sdata;

    aud4_link #(.BCLK_HALF(HALF), .PASS_THRU(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_samples(tx_samples),
        .tx_bclk(tx_bclk), .tx_ident(tx_ident), .tx_sdata(tx_sdata),
        .rx_bclk(rx_bclk), .rx_ident(rx_ident), .rx_sdata(rx_sdata),
        .rx_samples(rx_samples), .rx_valid(rx_valid), .rx_err(rx_err),
        .thru_sdata(thru_sdata)
    );

    localparam logic [63:0] VEC [0:5] = '{
        64'h0001_8000_7FFF_FFFF,
        64'hA5A5_5A5A_0F0F_F0F0,
        64'h1234_5678_9ABC_DEF0,
        64'h8000_0000_0000_0001,
        64'hFFFF_0000_FFFF_0000,
        64'hC3C3_3C3C_DEAD_BEEF
    };

    int total = 0;
    int bad   = 0;
    int valid_cnt = 0;
    int err_cnt   = 0;
    int r3_bad = 0;
    int r9_bad = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // pulse counters and edge-alignment monitors
    logic p_bclk, p_sd, p_id, p_rxsd;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) valid_cnt++;
            if (rx_err)   err_cnt++;
        end
        if (mon_on && !man_mode) begin
            if ((tx_sdata !== p_sd || tx_ident !== p_id) && !(p_bclk && !tx_bclk)) r3_bad++;
            if (thru_sdata !== p_rxsd) r9_bad++;
        end
        p_bclk = tx_bclk;
        p_sd   = tx_sdata;
        p_id   = tx_ident;
        p_rxsd = rx_sdata;
    end

    task automatic wait_bclk_rise();
        logic p;
        p = tx_bclk;
        @(negedge clk);
        while (!(tx_bclk && !p)) begin
            p = tx_bclk;
            @(negedge clk);
        end
    endtask

    task automatic wait_ident_fall();
        logic p;
        p = tx_ident;
        @(negedge clk);
        while (!(!tx_ident && p)) begin
            p = tx_ident;
            @(negedge clk);
        end
    endtask

    task automatic wait_new_valid();
        while (rx_valid) @(negedge clk);
        while (!rx_valid) @(negedge clk);
    endtask

    task automatic send_bit(input logic d, input logic id);
        man_sdata = d;
        man_ident = id;
        man_bclk  = 1'b0;
        repeat (HALF) @(negedge clk);
        man_bclk  = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_frame(input logic [63:0] f, input int n);
        for (int i = 0; i < n; i++) send_bit((i < 64) ? f[i] : 1'b0, i == n - 1);
        man_ident = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hi, lo, v0, e0;
        logic [63:0] cap, idb;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(tx_bclk === 1'b1 && tx_ident === 1'b0 && tx_sdata === 1'b0, "R1 tx idle",
            {61'd0, tx_bclk, tx_ident, tx_sdata}, 64'd4);
        chk(rx_valid === 1'b0 && rx_err === 1'b0 && thru_sdata === 1'b0 && rx_samples === '0,
            "R1 rx idle", rx_samples, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R2 bit clock shape
        wait_bclk_rise();
        hi = 1;
        forever begin @(negedge clk); if (!tx_bclk) break; hi++; end
        lo = 1;
        forever begin @(negedge clk); if (tx_bclk) break; lo++; end
        chk(hi == HALF, "R2 high time", 64'(hi), 64'(HALF));
        chk(lo == HALF, "R2 low time", 64'(lo), 64'(HALF));

        // first frame after reset carries zeros (R7)
        wait_new_valid();
        chk(rx_samples === '0 && !rx_err, "R7 first frame", rx_samples, 64'd0);

        // vector table through the loop (R4 channel layout, R7 latch)
        for (int i = 0; i < 6; i++) begin
            wait_new_valid();
            tx_valid   = 1'b1;
            tx_samples = VEC[i];
            @(negedge clk);
            tx_valid   = 1'b0;
            tx_samples = '0;
            wait_new_valid();
            chk(rx_samples === VEC[i] && !rx_err, "R7 loop vector", rx_samples, VEC[i]);
        end

        // R4/R5 wire-level frame capture of held samples
        wait_ident_fall();
        cap = '0;
        idb = '0;
        for (int b = 0; b < 64; b++) begin
            wait_bclk_rise();
            cap[b] = tx_sdata;
            idb[b] = tx_ident;
        end
        chk(cap === VEC[5], "R4 bit order", cap, VEC[5]);
        chk(idb === 64'h8000_0000_0000_0000, "R5 ident position", idb, 64'h8000_0000_0000_0000);

        // R6 held samples are resent
        wait_new_valid();
        chk(rx_samples === VEC[5], "R6 repeat held", rx_samples, VEC[5]);

        // R6 new samples in the load cycle win
        do wait_bclk_rise(); while (!tx_ident);
        repeat (HALF - 1) @(negedge clk);
        tx_valid = 1'b1; tx_samples = VEC[0];
        @(negedge clk);
        tx_valid = 1'b0; tx_samples = '0;
        wait_new_valid();
        chk(rx_samples === VEC[0], "R6 coincident load", rx_samples, VEC[0]);

        // R6 samples one cycle after the load wait a frame
        do wait_bclk_rise(); while (!tx_ident);
        repeat (HALF) @(negedge clk);
        tx_valid = 1'b1; tx_samples = VEC[1];
        @(negedge clk);
        tx_valid = 1'b0; tx_samples = '0;
        wait_new_valid();
        chk(rx_samples === VEC[0], "R6 late sample deferred", rx_samples, VEC[0]);
        wait_new_valid();
        chk(rx_samples === VEC[1], "R6 late sample next frame", rx_samples, VEC[1]);

        chk(r3_bad == 0, "R3 change only on fall", 64'(r3_bad), 64'd0);
        chk(r9_bad == 0, "R9 pass-through delay", 64'(r9_bad), 64'd0);

        // receive pins driven directly: R8 / R10
        mon_on = 1'b0;
        rst_n = 1'b0;
        man_mode = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        v0 = valid_cnt; e0 = err_cnt;
        send_frame(VEC[2], 64);
        chk(valid_cnt == v0 + 1 && err_cnt == e0, "R7 direct good frame", 64'(valid_cnt - v0), 64'd1);
        chk(rx_samples === VEC[2], "R7 direct data", rx_samples, VEC[2]);

        v0 = valid_cnt; e0 = err_cnt;
        send_frame(VEC[4], 40);
        chk(err_cnt == e0 + 1 && valid_cnt == v0, "R8 short frame err", 64'(err_cnt - e0), 64'd1);
        chk(rx_samples === VEC[2], "R8 short frame kept", rx_samples, VEC[2]);

        v0 = valid_cnt; e0 = err_cnt;
        send_frame(VEC[3], 64);
        chk(valid_cnt == v0 + 1 && err_cnt == e0, "R8 recount after err", 64'(valid_cnt - v0), 64'd1);
        chk(rx_samples === VEC[3], "R8 recount data", rx_samples, VEC[3]);

        v0 = valid_cnt; e0 = err_cnt;
        send_frame(VEC[1], 70);
        chk(err_cnt == e0 + 1 && valid_cnt == v0, "R8 long frame err", 64'(err_cnt - e0), 64'd1);
        repeat (20) @(negedge clk);
        chk(rx_samples === VEC[3], "R10 hold after reject", rx_samples, VEC[3]);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule